// File: doc/BRIEF.md
# Serial Port Control/Status Register Front End

This block sits between a word-addressed register bus and the two 16-entry character queues and line shifters of an asynchronous serial port. A bus write to the data offset puts a character into the transmit queue. A bus read of the data offset returns the head of the receive queue and removes it. The other offsets hold line configuration, baud divisor, interrupt enables, flow control settings and the two queue thresholds. The block drives these settings out to the shifters as plain configuration outputs.

Live status is put together every cycle from the queue levels, the transmit shifter's activity and a synchronised clear-to-send input. Error and break strobes from the receiver are kept in a sticky status word until software writes that register. Four interrupt sources are gated by their enable bits and latched into a pending word, which software clears by writing it. The single interrupt line is the OR of the pending bits.

Read data is combinational from the request in the same cycle. A receive pop and a transmit push take effect at the clock edge that ends the request cycle.

Top module: `uart_csr_front`

## Requirements
- R1: After reset every configuration register, the sticky status, the pending interrupt word and `irq` are zero. The flag register then reads 0x90 with both queues empty, the shifter idle and CTS low.
- R2: A write to offset 0x00 drives `tx_push` for that cycle with `tx_push_data` equal to `req_wdata[7:0]`. The push is suppressed when `tx_level` equals 16.
- R3: A read of offset 0x00 returns `rx_pop_data` in bits 7:0 and drives `rx_pop` for that cycle when `rx_level` is nonzero. With an empty receive queue it returns 0 and does not pop.
- R4: Offsets 0x08 (line control, 7 bits), 0x0C/0x10 (divisor high/low byte), 0x14 (control; bits 1 and 2 always read 0), 0x24 (flow control, 8 bits), 0x38 and 0x3C (receive/transmit thresholds, 5 bits) read back what was written. The same values appear on the `cfg_*` outputs.
- R5: Flags at 0x18: bit 0 synchronised CTS, bit 3 busy (transmit queue not empty or `tx_active`), bit 4 receive queue empty, bit 5 transmit queue full, bit 6 receive queue full, bit 7 transmit queue empty. Other bits read 0.
- R6: Status at 0x04 holds sticky bits: bit 0 framing, bit 1 parity, bit 2 break, bit 3 overrun, each set by its one-cycle strobe. Any write to 0x04 clears all four, but a strobe in the same cycle still sets its bit.
- R7: Pending bit 1 (receive) latches when control bit 4 is set and `rx_level` is at or above the receive threshold.
- R8: Pending bit 2 (transmit) latches when control bit 5 is set and `tx_level` is at or below the transmit threshold.
- R9: Pending bit 0 (modem status) latches on any change of the two-stage synchronised `cts_in` while control bit 3 is set. A change while that bit is clear leaves it unset.
- R10: Pending bit 3 (receive timeout) latches on an `rx_timeout` strobe while control bit 6 is set.
- R11: A write to offset 0x1C clears all pending bits. A source still true sets its bit again one clock later. `irq` is the OR of the pending bits and reads back at 0x1C bits 3:0.
- R12: Reads of offsets not listed above return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset, word aligned |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the request cycle |
| tx_push | output | 1 | Push strobe to transmit queue |
| tx_push_data | output | 8 | Character to push |
| tx_level | input | 5 | Transmit queue fill level |
| rx_pop | output | 1 | Pop strobe to receive queue |
| rx_pop_data | input | 8 | Head of receive queue |
| rx_level | input | 5 | Receive queue fill level |
| tx_active | input | 1 | Transmit shifter busy |
| err_frame | input | 1 | Framing error strobe |
| err_parity | input | 1 | Parity error strobe |
| err_break | input | 1 | Break detect strobe |
| err_overrun | input | 1 | Overrun strobe |
| rx_timeout | input | 1 | Receive timeout strobe |
| cts_in | input | 1 | Asynchronous clear-to-send |
| cfg_line | output | 7 | Line control setting |
| cfg_ctrl | output | 8 | Control setting |
| cfg_divisor | output | 16 | Baud divisor {high, low} |
| cfg_flow | output | 8 | Flow control setting |
| cfg_rx_thresh | output | 5 | Receive threshold |
| cfg_tx_thresh | output | 5 | Transmit threshold |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check on every cycle that a push never reaches a full transmit queue, that a pop never reaches an empty receive queue, and that a receive or transmit pending bit rises only after its enable was set. They also check that a status write with no strobe present leaves the status word empty, and that clearing the pending word with all enables off keeps it empty. Only the bench scenarios can show the absolute values that matter: flag encodings under each queue state, which values read back from each register, how sticky bits combine across strobes, and the re-raise of a source that is still true after a clear. They also cover the two-stage CTS delay before a modem status event and the masking of sources whose enable is off.

// File: rtl/uart_csr_front.sv
module uart_csr_front #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [BUS_W-1:0]              req_wdata,
  output logic [BUS_W-1:0]              rd_data,
  output logic                          tx_push,
  output logic [DATA_W-1:0]             tx_push_data,
  input  logic [$clog2(DEPTH+1)-1:0]    tx_level,
  output logic                          rx_pop,
  input  logic [DATA_W-1:0]             rx_pop_data,
  input  logic [$clog2(DEPTH+1)-1:0]    rx_level,
  input  logic                          tx_active,
  input  logic                          err_frame,
  input  logic                          err_parity,
  input  logic                          err_break,
  input  logic                          err_overrun,
  input  logic                          rx_timeout,
  input  logic                          cts_in,
  output logic [6:0]                    cfg_line,
  output logic [7:0]                    cfg_ctrl,
  output logic [15:0]                   cfg_divisor,
  output logic [7:0]                    cfg_flow,
  output logic [$clog2(DEPTH+1)-1:0]    cfg_rx_thresh,
  output logic [$clog2(DEPTH+1)-1:0]    cfg_tx_thresh,
  output logic                          irq
);
  localparam int LVL_W = $clog2(DEPTH+1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_DIVH = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_DIVL = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_FLOW = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_RXTH = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] A_TXTH = ADDR_W'(8'h3C);
  localparam logic [7:0] CTRL_MASK = 8'hF9;

  logic             wr, rd;
  logic [6:0]       line_q;
  logic [7:0]       ctrl_q, divh_q, divl_q, flow_q;
  logic [LVL_W-1:0] rxth_q, txth_q;
  logic [3:0]       stat_q, stat_set;
  logic [3:0]       pend_q, pend_set;
  logic             cts_m, cts_s, cts_d;
  logic [7:0]       flags;

  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;

  assign tx_push      = wr && req_addr == A_DATA && tx_level != FULL_LVL;
  assign tx_push_data = req_wdata[DATA_W-1:0];
  assign rx_pop       = rd && req_addr == A_DATA && rx_level != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      ctrl_q <= '0;
      divh_q <= '0;
      divl_q <= '0;
      flow_q <= '0;
      rxth_q <= '0;
      txth_q <= '0;
    end else if (wr) begin
      case (req_addr)
        A_LINE: line_q <= req_wdata[6:0];
        A_CTRL: ctrl_q <= req_wdata[7:0] & CTRL_MASK;
        A_DIVH: divh_q <= req_wdata[7:0];
        A_DIVL: divl_q <= req_wdata[7:0];
        A_FLOW: flow_q <= req_wdata[7:0];
        A_RXTH: rxth_q <= req_wdata[LVL_W-1:0];
        A_TXTH: txth_q <= req_wdata[LVL_W-1:0];
        default: ;
      endcase
    end
  end

  assign stat_set = {err_overrun, err_break, err_parity, err_frame};

  always_ff @(posedge clk) begin
    if (!rst_n)                        stat_q <= '0;
    else if (wr && req_addr == A_STAT) stat_q <= stat_set;
    else                               stat_q <= stat_q | stat_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cts_m <= 1'b0;
      cts_s <= 1'b0;
      cts_d <= 1'b0;
    end else begin
      cts_m <= cts_in;
      cts_s <= cts_m;
      cts_d <= cts_s;
    end
  end

  assign pend_set[0] = ctrl_q[3] & (cts_s ^ cts_d);
  assign pend_set[1] = ctrl_q[4] & (rx_level >= rxth_q);
  assign pend_set[2] = ctrl_q[5] & (tx_level <= txth_q);
  assign pend_set[3] = ctrl_q[6] & rx_timeout;

  always_ff @(posedge clk) begin
    if (!rst_n)                        pend_q <= '0;
    else if (wr && req_addr == A_PEND) pend_q <= '0;
    else                               pend_q <= pend_q | pend_set;
  end

  assign irq = |pend_q;

  assign flags = {tx_level == '0, rx_level == FULL_LVL, tx_level == FULL_LVL,
                  rx_level == '0, (tx_level != '0) | tx_active, 2'b00, cts_s};

  always_comb begin
    rd_data = '0;
    if (rd) begin
      case (req_addr)
        A_DATA: if (rx_level != '0) rd_data[DATA_W-1:0] = rx_pop_data;
        A_STAT: rd_data[3:0]       = stat_q;
        A_LINE: rd_data[6:0]       = line_q;
        A_DIVH: rd_data[7:0]       = divh_q;
        A_DIVL: rd_data[7:0]       = divl_q;
        A_CTRL: rd_data[7:0]       = ctrl_q;
        A_FLAG: rd_data[7:0]       = flags;
        A_PEND: rd_data[3:0]       = pend_q;
        A_FLOW: rd_data[7:0]       = flow_q;
        A_RXTH: rd_data[LVL_W-1:0] = rxth_q;
        A_TXTH: rd_data[LVL_W-1:0] = txth_q;
        default: ;
      endcase
    end
  end

  assign cfg_line      = line_q;
  assign cfg_ctrl      = ctrl_q;
  assign cfg_divisor   = {divh_q, divl_q};
  assign cfg_flow      = flow_q;
  assign cfg_rx_thresh = rxth_q;
  assign cfg_tx_thresh = txth_q;

  assert_push_not_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> tx_level != FULL_LVL);

  assert_pop_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_level != '0);

  assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_STAT && stat_set == '0) |=> stat_q == '0);

  assert_rx_pend_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[1]) |-> $past(ctrl_q[4]));

  assert_tx_pend_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[2]) |-> $past(ctrl_q[5]));

  assert_pend_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_PEND && ctrl_q[6:3] == 4'b0) |=> pend_q == '0);
endmodule

// File: tb/test_uart_csr_front.sv
module test_uart_csr_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        tx_push, rx_pop;
  logic [7:0]  tx_push_data;
  logic [4:0]  tx_level = '0, rx_level = '0;
  logic [7:0]  rx_pop_data = '0;
  logic        tx_active = 1'b0;
  logic        err_frame = 1'b0, err_parity = 1'b0, err_break = 1'b0, err_overrun = 1'b0;
  logic        rx_timeout = 1'b0, cts_in = 1'b0;
  logic [6:0]  cfg_line;
  logic [7:0]  cfg_ctrl, cfg_flow;
  logic [15:0] cfg_divisor;
  logic [4:0]  cfg_rx_thresh, cfg_tx_thresh;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  int     exp_q[$];
  bit     pop_q[$];
  string  tag_q[$];

  always #5 clk = ~clk;

  uart_csr_front i_uart_csr_front (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_level(tx_level),
    .rx_pop(rx_pop), .rx_pop_data(rx_pop_data), .rx_level(rx_level),
    .tx_active(tx_active), .err_frame(err_frame), .err_parity(err_parity),
    .err_break(err_break), .err_overrun(err_overrun), .rx_timeout(rx_timeout),
    .cts_in(cts_in), .cfg_line(cfg_line), .cfg_ctrl(cfg_ctrl),
    .cfg_divisor(cfg_divisor), .cfg_flow(cfg_flow), .cfg_rx_thresh(cfg_rx_thresh),
    .cfg_tx_thresh(cfg_tx_thresh), .irq(irq));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // scoreboard monitor: compares each read against the queued expectation
  initial forever begin
    @(negedge clk);
    #3;
    if (req_valid && !req_write) begin
      if (exp_q.size() == 0) check("monitor: unexpected read", 1, 0);
      else begin
        automatic int    e = exp_q.pop_front();
        automatic bit    p = pop_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, int'(rd_data), e);
        check({t, " pop"}, int'(rx_pop), int'(p));
      end
    end
  end

  task automatic rd(input logic [7:0] a, input int exp, input bit pop, input string tag);
    exp_q.push_back(exp);
    pop_q.push_back(pop);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr_push(input logic [31:0] d, input bit exp_push, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_wdata = d;
    #3;
    check({tag, " push"}, int'(tx_push), int'(exp_push));
    if (exp_push) check({tag, " data"}, int'(tx_push_data), int'(d[7:0]));
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: err_frame = 1'b1;
      1: err_parity = 1'b1;
      2: begin err_break = 1'b1; err_overrun = 1'b1; end
      default: rx_timeout = 1'b1;
    endcase
    @(negedge clk);
    err_frame = 0; err_parity = 0; err_break = 0; err_overrun = 0; rx_timeout = 0;
  endtask

  task automatic chk_irq(input bit exp, input string tag);
    @(negedge clk); #3;
    check(tag, int'(irq), int'(exp));
  endtask

  initial begin
    #1_000_000;
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd(8'h08, 0, 0, "R1 line");
    rd(8'h14, 0, 0, "R1 ctrl");
    rd(8'h04, 0, 0, "R1 status");
    rd(8'h1C, 0, 0, "R1 pending");
    rd(8'h18, 'h90, 0, "R1 R5 idle flags");
    chk_irq(0, "R1 irq");

    // R4 register readback
    wr(8'h08, 32'hFF);  rd(8'h08, 'h7F, 0, "R4 line");
    wr(8'h14, 32'hFF);  rd(8'h14, 'hF9, 0, "R4 ctrl");
    check("R4 cfg_ctrl", int'(cfg_ctrl), 'hF9);
    wr(8'h14, 32'h0);   wr(8'h1C, 32'h0);
    wr(8'h0C, 32'h12);  wr(8'h10, 32'h34);
    rd(8'h0C, 'h12, 0, "R4 div high");
    check("R4 cfg_divisor", int'(cfg_divisor), 'h1234);
    wr(8'h24, 32'hA5);  rd(8'h24, 'hA5, 0, "R4 flow");
    wr(8'h38, 32'h3F);  rd(8'h38, 'h1F, 0, "R4 rx thresh");
    wr(8'h3C, 32'h07);  rd(8'h3C, 'h07, 0, "R4 tx thresh");
    check("R4 cfg_line", int'(cfg_line), 'h7F);

    // R12 unmapped
    wr(8'h20, 32'hFFFF);
    rd(8'h20, 0, 0, "R12 unmapped 0x20");
    rd(8'h40, 0, 0, "R12 unmapped 0x40");
    rd(8'h24, 'hA5, 0, "R12 flow untouched");

    // R2 transmit push
    tx_level = 5'd3;
    wr_push(32'h1A5, 1, "R2 not full");
    tx_level = 5'd16;
    wr_push(32'h5A, 0, "R2 full");
    rd(8'h18, 'h38, 0, "R5 tx full flags");

    // R3 receive pop
    tx_level = 5'd0; rx_level = 5'd2; rx_pop_data = 8'h5C;
    rd(8'h00, 'h5C, 1, "R3 pop head");
    rx_level = 5'd0;
    rd(8'h00, 0, 0, "R3 empty");
    rx_level = 5'd16; tx_active = 1'b1;
    rd(8'h18, 'hC8, 0, "R5 rx full busy");
    tx_active = 1'b0; rx_level = 5'd0;

    // R6 sticky status
    pulse(0); rd(8'h04, 'h1, 0, "R6 frame");
    pulse(1); rd(8'h04, 'h3, 0, "R6 parity");
    pulse(2); rd(8'h04, 'hF, 0, "R6 break overrun");
    wr(8'h04, 32'h0); rd(8'h04, 0, 0, "R6 cleared");
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h04; err_overrun = 1;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; err_overrun = 0;
    rd(8'h04, 'h8, 0, "R6 set beats clear");

    // R7 receive interrupt
    wr(8'h38, 32'd4); rx_level = 5'd3;
    wr(8'h14, 32'h10); idle(2);
    rd(8'h1C, 0, 0, "R7 below threshold");
    rx_level = 5'd4; idle(2);
    rd(8'h1C, 'h2, 0, "R7 at threshold");
    chk_irq(1, "R7 R11 irq");
    wr(8'h1C, 32'h0); idle(2);
    rd(8'h1C, 'h2, 0, "R11 re-raise");
    rx_level = 5'd0; wr(8'h1C, 32'h0); idle(2);
    rd(8'h1C, 0, 0, "R11 cleared");
    chk_irq(0, "R11 irq low");
    wr(8'h14, 32'h0);

    // R8 transmit interrupt
    tx_level = 5'd5; wr(8'h3C, 32'd2);
    wr(8'h14, 32'h20); idle(2);
    rd(8'h1C, 0, 0, "R8 above threshold");
    tx_level = 5'd2; idle(2);
    rd(8'h1C, 'h4, 0, "R8 at threshold");
    tx_level = 5'd3; wr(8'h1C, 32'h0); idle(2);
    rd(8'h1C, 0, 0, "R8 cleared");
    wr(8'h14, 32'h0);

    // R9 modem status
    wr(8'h14, 32'h08);
    @(negedge clk) cts_in = 1'b1;
    idle(4);
    rd(8'h1C, 'h1, 0, "R9 cts change");
    rd(8'h18, 'h19, 0, "R9 R5 cts flag");
    wr(8'h14, 32'h0); wr(8'h1C, 32'h0);
    @(negedge clk) cts_in = 1'b0;
    idle(4);
    rd(8'h1C, 0, 0, "R9 masked change");

    // R10 receive timeout
    wr(8'h14, 32'h40);
    pulse(3); idle(1);
    rd(8'h1C, 'h8, 0, "R10 timeout");
    wr(8'h14, 32'h0); wr(8'h1C, 32'h0);
    pulse(3); idle(1);
    rd(8'h1C, 0, 0, "R10 masked");

    // R7 R8 together
    rx_level = 5'd4; tx_level = 5'd2;
    wr(8'h14, 32'h30); idle(2);
    rd(8'h1C, 'h6, 0, "R7 R8 combined");
    chk_irq(1, "R11 combined irq");

    idle(2);
    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule